// File: doc/BRIEF.md
# Interlaced Standard-Definition Raster Timer

This block produces the raster timing for interlaced standard-definition video at a nominal 27 MHz pixel clock (about 37 ns per pixel). One clock advances a pixel counter across a line. Each pixel-counter wrap advances a line counter across the frame. From the two counters the block decodes four flags: horizontal blank, vertical blank, active picture and field identity. The counters themselves are also brought out, so downstream logic can address pixel data.

Two raster geometries are available: a 525-line format and a 625-line format. A three-state controller holds the current geometry. Its states are `ST_OFF`, `ST_FMT525` and `ST_FMT625`. In `ST_OFF` the counters sit at their start values and every flag is low. The controller has three transitions:
- **Leave off:** `ST_OFF` goes to a running state on the next clock after `mode_in` selects a format.
- **Frame swap:** a running state goes to whichever state `mode_in` selects, including `ST_OFF`, but only on the clock that moves the line counter from the last line back to line 1.
- **Hold:** every other clock keeps the current state.

An enable input freezes or releases the counters.

Top module: `sd_raster_timer`

## Requirements
- R1: After reset, and whenever the controller is in `ST_OFF`, the outputs hold fixed values. `pix_count` is 0, `line_count` is 1, and `hblank`, `vblank`, `active` and `field` are all 0. The `mode_in` code 0 selects off, and the code 3 is also treated as off.
- R2: In a running state, each clock with `enable` high advances `pix_count`. It counts from 0 up to ACTIVE_PIX+HBLANK−1 and then returns to 0. On that return, `line_count` steps from 1 up to N and then back to 1. One frame therefore lasts (ACTIVE_PIX+HBLANK)·N enabled clocks. With the defaults this is 982·525 for the 525-line format and 994·625 for the 625-line format.
- R3: `hblank` is high exactly when `pix_count` ≥ ACTIVE_PIX, which is 720 by default. The blanking interval lasts 262 clocks in the 525-line format and 274 clocks in the 625-line format.
- R4: The first vertical blanking window covers line N/2 through line N/2+(N−A)/2, both ends included. N is the number of lines and A the number of active lines, and both divisions are integer. This is lines 262..284 for 525/480 and lines 312..336 for 625/576.
- R5: The second vertical blanking window covers line N and then lines 1 through (N+(N−A)/2−1) mod N, so it wraps across the frame boundary. That upper bound is line 21 for the 525-line format and line 23 for the 625-line format. Counting across the wrap, the window holds 22 lines and 24 lines respectively.
- R6: `active` is high only when `pix_count` < ACTIVE_PIX and the current line is in neither blanking window. This gives 240 active lines in each field of the 525-line format, and 288 in each field of the 625-line format.
- R7: `field` is 0 on lines 1..N/2 and 1 on lines N/2+1..N. It therefore changes only at `pix_count` 0.
- R8: The `mode_in` codes are 1 for 525 lines and 2 for 625 lines. A change of `mode_in` during a running frame has no effect until the enabled clock on which the last pixel of line N wraps. On that clock the new state is taken, so a frame is never cut short. From `ST_OFF`, the selected format is taken on the next clock, and counting begins on the clock after that.
- R9: While `enable` is low, `pix_count`, `line_count` and all flags keep their values. A wrap that would fall on such a clock does not happen, so no mode change can occur on it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Counters advance while high |
| mode_in | input | 2 | Requested format: 0 off, 1 525-line, 2 625-line, 3 off |
| pix_count | output | PIX_W (10) | Pixel position in the line, 0-based |
| line_count | output | LINE_W (10) | Line position in the frame, 1-based |
| hblank | output | 1 | Horizontal blanking interval |
| vblank | output | 1 | Inside either vertical blanking window |
| active | output | 1 | Active picture sample |
| field | output | 1 | 0 in the first field, 1 in the second |

## Verification
The frame-wrap clock is where the counter wrap and a pending format change fall together. A further collision comes when `enable` drops on that same clock. The bench steers the raster to the last pixel of line N with a different `mode_in` already waiting. It then holds `enable` low for one clock, which must leave both the counters and the format untouched. It then raises `enable` for one clock, on which the counters must return to line 1, pixel 0 and the new geometry must take effect. Random enable gaps and random format requests are mixed in. Every cycle is compared against a bench model built from the requirements, and whole frames in both formats are measured for active-line, wrap-blank and clock totals.

// File: rtl/sdrt_pkg.sv
package sdrt_pkg;

    typedef enum logic [1:0] {
        ST_OFF    = 2'd0,
        ST_FMT525 = 2'd1,
        ST_FMT625 = 2'd2
    } sdrt_state_e;

    // Map the external format code onto a controller state.
    function automatic sdrt_state_e code_to_state(input logic [1:0] code);
        case (code)
            2'd1:    return ST_FMT525;
            2'd2:    return ST_FMT625;
            default: return ST_OFF;
        endcase
    endfunction

endpackage

// File: rtl/sdrt_mode_fsm.sv
module sdrt_mode_fsm
    import sdrt_pkg::*;
#(
    parameter int ACTIVE_PIX  = 720,
    parameter int HBLANK_525  = 262,
    parameter int HBLANK_625  = 274,
    parameter int LINES_525   = 525,
    parameter int ACTLN_525   = 480,
    parameter int LINES_625   = 625,
    parameter int ACTLN_625   = 576,
    parameter int PIX_W       = 10,
    parameter int LINE_W      = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        mode_in,
    input  logic              frame_end,
    output sdrt_state_e       state_q,
    output logic              running,
    output logic [PIX_W-1:0]  pix_last,
    output logic [LINE_W-1:0] line_total,
    output logic [LINE_W-1:0] field_half,
    output logic [LINE_W-1:0] vb1_end,
    output logic [LINE_W-1:0] vb2_end
);

    localparam logic [PIX_W-1:0]  LAST_525 = PIX_W'(ACTIVE_PIX + HBLANK_525 - 1);
    localparam logic [PIX_W-1:0]  LAST_625 = PIX_W'(ACTIVE_PIX + HBLANK_625 - 1);
    localparam int                GAP_525  = (LINES_525 - ACTLN_525) / 2;
    localparam int                GAP_625  = (LINES_625 - ACTLN_625) / 2;
    localparam logic [LINE_W-1:0] HALF_525 = LINE_W'(LINES_525 / 2);
    localparam logic [LINE_W-1:0] HALF_625 = LINE_W'(LINES_625 / 2);
    localparam logic [LINE_W-1:0] E1_525   = LINE_W'(LINES_525 / 2 + GAP_525);
    localparam logic [LINE_W-1:0] E1_625   = LINE_W'(LINES_625 / 2 + GAP_625);
    localparam logic [LINE_W-1:0] E2_525   = LINE_W'((LINES_525 + GAP_525 - 1) % LINES_525);
    localparam logic [LINE_W-1:0] E2_625   = LINE_W'((LINES_625 + GAP_625 - 1) % LINES_625);

    sdrt_state_e state_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    // Next state: leave-off, frame-swap, hold
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF:    state_d = code_to_state(mode_in);
            ST_FMT525,
            ST_FMT625: if (frame_end) state_d = code_to_state(mode_in);
            default:   state_d = ST_OFF;
        endcase
    end

    // Outputs: geometry of the current state
    always_comb begin
        running    = 1'b0;
        pix_last   = LAST_525;
        line_total = LINE_W'(LINES_525);
        field_half = HALF_525;
        vb1_end    = E1_525;
        vb2_end    = E2_525;
        unique case (state_q)
            ST_OFF: running = 1'b0;
            ST_FMT525: running = 1'b1;
            ST_FMT625: begin
                running    = 1'b1;
                pix_last   = LAST_625;
                line_total = LINE_W'(LINES_625);
                field_half = HALF_625;
                vb1_end    = E1_625;
                vb2_end    = E2_625;
            end
            default: running = 1'b0;
        endcase
    end

endmodule

// File: rtl/sdrt_raster_cnt.sv
module sdrt_raster_cnt #(
    parameter int PIX_W  = 10,
    parameter int LINE_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              running,
    input  logic [PIX_W-1:0]  pix_last,
    input  logic [LINE_W-1:0] line_total,
    output logic [PIX_W-1:0]  pix_q,
    output logic [LINE_W-1:0] line_q,
    output logic              frame_end
);

    logic line_end;

    assign line_end  = running && enable && (pix_q == pix_last);
    assign frame_end = line_end && (line_q == line_total);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pix_q  <= '0;
            line_q <= LINE_W'(1);
        end else if (!running) begin
            pix_q  <= '0;
            line_q <= LINE_W'(1);
        end else if (enable) begin
            if (line_end) begin
                pix_q  <= '0;
                line_q <= frame_end ? LINE_W'(1) : line_q + LINE_W'(1);
            end else begin
                pix_q  <= pix_q + PIX_W'(1);
            end
        end
    end

endmodule

// File: rtl/sdrt_flag_decode.sv
module sdrt_flag_decode #(
    parameter int ACTIVE_PIX = 720,
    parameter int PIX_W      = 10,
    parameter int LINE_W     = 10
) (
    input  logic              running,
    input  logic [PIX_W-1:0]  pix_q,
    input  logic [LINE_W-1:0] line_q,
    input  logic [LINE_W-1:0] line_total,
    input  logic [LINE_W-1:0] field_half,
    input  logic [LINE_W-1:0] vb1_end,
    input  logic [LINE_W-1:0] vb2_end,
    output logic              hblank,
    output logic              vblank,
    output logic              active,
    output logic              field
);

    logic in_h, in_win1, in_win2;

    always_comb begin
        in_h    = (pix_q >= PIX_W'(ACTIVE_PIX));
        in_win1 = (line_q >= field_half) && (line_q <= vb1_end);
        in_win2 = (line_q == line_total) || (line_q <= vb2_end);
        hblank  = running && in_h;
        vblank  = running && (in_win1 || in_win2);
        active  = running && !in_h && !in_win1 && !in_win2;
        field   = running && (line_q > field_half);
    end

endmodule

// File: rtl/sd_raster_timer.sv
module sd_raster_timer
    import sdrt_pkg::*;
#(
    parameter int ACTIVE_PIX = 720,
    parameter int HBLANK_525 = 262,
    parameter int HBLANK_625 = 274,
    parameter int LINES_525  = 525,
    parameter int ACTLN_525  = 480,
    parameter int LINES_625  = 625,
    parameter int ACTLN_625  = 576,
    localparam int TOT_MAX   = ACTIVE_PIX + ((HBLANK_525 > HBLANK_625) ? HBLANK_525 : HBLANK_625),
    localparam int LN_MAX    = (LINES_525 > LINES_625) ? LINES_525 : LINES_625,
    localparam int PIX_W     = $clog2(TOT_MAX),
    localparam int LINE_W    = $clog2(LN_MAX + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic [1:0]        mode_in,
    output logic [PIX_W-1:0]  pix_count,
    output logic [LINE_W-1:0] line_count,
    output logic              hblank,
    output logic              vblank,
    output logic              active,
    output logic              field
);

    sdrt_state_e       state_q;
    logic              running, frame_end;
    logic [PIX_W-1:0]  pix_last;
    logic [LINE_W-1:0] line_total, field_half, vb1_end, vb2_end;

    sdrt_mode_fsm #(
        .ACTIVE_PIX(ACTIVE_PIX), .HBLANK_525(HBLANK_525), .HBLANK_625(HBLANK_625),
        .LINES_525(LINES_525), .ACTLN_525(ACTLN_525),
        .LINES_625(LINES_625), .ACTLN_625(ACTLN_625),
        .PIX_W(PIX_W), .LINE_W(LINE_W)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .mode_in(mode_in), .frame_end(frame_end),
        .state_q(state_q), .running(running), .pix_last(pix_last),
        .line_total(line_total), .field_half(field_half),
        .vb1_end(vb1_end), .vb2_end(vb2_end)
    );

    sdrt_raster_cnt #(.PIX_W(PIX_W), .LINE_W(LINE_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .enable(enable), .running(running),
        .pix_last(pix_last), .line_total(line_total),
        .pix_q(pix_count), .line_q(line_count), .frame_end(frame_end)
    );

    sdrt_flag_decode #(.ACTIVE_PIX(ACTIVE_PIX), .PIX_W(PIX_W), .LINE_W(LINE_W)) u_dec (
        .running(running), .pix_q(pix_count), .line_q(line_count),
        .line_total(line_total), .field_half(field_half),
        .vb1_end(vb1_end), .vb2_end(vb2_end),
        .hblank(hblank), .vblank(vblank), .active(active), .field(field)
    );

endmodule

// File: rtl/sdrt_checker.sv
module sdrt_checker
    import sdrt_pkg::*;
#(
    parameter int ACTIVE_PIX = 720,
    parameter int PIX_W      = 10,
    parameter int LINE_W     = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              enable,
    input sdrt_state_e       state_q,
    input logic              running,
    input logic [PIX_W-1:0]  pix_count,
    input logic [LINE_W-1:0] line_count,
    input logic              hblank,
    input logic              vblank,
    input logic              active,
    input logic              field
);

    assert_off_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !running |-> (!hblank && !vblank && !active && !field &&
                      pix_count == '0 && line_count == LINE_W'(1)));

    assert_pix_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(running) && $past(enable) && pix_count != '0)
            |-> pix_count == PIX_W'($past(pix_count) + 1'b1));

    assert_line_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_count != '0) |-> $stable(line_count));

    assert_hblank_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hblank) |-> pix_count == PIX_W'(ACTIVE_PIX));

    assert_wrap_blank_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (running && line_count == LINE_W'(1)) |-> vblank);

    assert_field_edge_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(field) |-> pix_count == '0);

    assert_mode_boundary_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(running) && !$stable(state_q))
            |-> (pix_count == '0 && line_count == LINE_W'(1)));

    assert_enable_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> ($stable(pix_count) && $stable(line_count)));

endmodule

bind sd_raster_timer sdrt_checker #(
    .ACTIVE_PIX(ACTIVE_PIX), .PIX_W(PIX_W), .LINE_W(LINE_W)
) u_sdrt_checker (
    .clk(clk), .rst_n(rst_n), .enable(enable), .state_q(state_q),
    .running(running), .pix_count(pix_count), .line_count(line_count),
    .hblank(hblank), .vblank(vblank), .active(active), .field(field)
);

// File: tb/sd_raster_timer_bench.sv
`timescale 1ns/1ps
module sd_raster_timer_bench;

    localparam int A   = 8;
    localparam int H5  = 4;
    localparam int H6  = 6;
    localparam int WDOG = 190000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b0;
    logic [1:0] mode_in = 2'd0;
    logic [3:0] pix_count;
    logic [9:0] line_count;
    logic       hblank, vblank, active, field;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc   = 0;

    // bench model state
    int m_st = 0, m_pix = 0, m_line = 1;

    always #5 clk = ~clk;

    sd_raster_timer #(.ACTIVE_PIX(A), .HBLANK_525(H5), .HBLANK_625(H6)) u_sd_raster_timer (
        .clk(clk), .rst_n(rst_n), .enable(enable), .mode_in(mode_in),
        .pix_count(pix_count), .line_count(line_count),
        .hblank(hblank), .vblank(vblank), .active(active), .field(field)
    );

    function automatic int f_tot(int st); return (st == 2) ? A + H6 : A + H5; endfunction
    function automatic int f_n(int st);   return (st == 2) ? 625 : 525; endfunction
    function automatic int f_act(int st); return (st == 2) ? 576 : 480; endfunction
    function automatic int f_dec(int code); return (code == 1 || code == 2) ? code : 0; endfunction
    function automatic bit f_vb(int st, int ln);
        int n, h, e1, e2;
        n = f_n(st); h = n / 2;
        e1 = h + (n - f_act(st)) / 2;
        e2 = (n + (n - f_act(st)) / 2 - 1) % n;
        return (st != 0) && ((ln >= h && ln <= e1) || ln == n || ln <= e2);
    endfunction

    task automatic chk(bit ok, string tag, string what, int act_v, int exp_v);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act_v, exp_v);
        end
    endtask

    task automatic compare_all();
        bit e_hb, e_vb, e_fd, e_ac;
        e_hb = (m_st != 0) && (m_pix >= A);
        e_vb = f_vb(m_st, m_line);
        e_fd = (m_st != 0) && (m_line > f_n(m_st) / 2);
        e_ac = (m_st != 0) && !e_hb && !e_vb;
        chk(int'(pix_count) == m_pix, "R2", "pix_count", int'(pix_count), m_pix);
        chk(int'(line_count) == m_line, "R2", "line_count", int'(line_count), m_line);
        chk(hblank == e_hb, "R3", "hblank", hblank, e_hb);
        chk(vblank == e_vb, (m_line > f_n(m_st) / 2 && m_line < f_n(m_st)) ? "R4" : "R5",
            "vblank", vblank, e_vb);
        chk(active == e_ac, "R6", "active", active, e_ac);
        chk(field == e_fd, "R7", "field", field, e_fd);
    endtask

    // Drive inputs, advance the model over one edge, compare at the next negedge.
    task automatic step(bit en, int md);
        enable  = en;
        mode_in = 2'(md);
        if (m_st == 0) begin
            m_st = f_dec(md); m_pix = 0; m_line = 1;
        end else if (en) begin
            if (m_pix == f_tot(m_st) - 1) begin
                m_pix = 0;
                if (m_line == f_n(m_st)) begin
                    m_line = 1; m_st = f_dec(md);
                end else m_line++;
            end else m_pix++;
        end
        @(posedge clk);
        @(negedge clk);
        compare_all();
    endtask

    task automatic goto_start(int md);
        while (!(m_st != 0 && m_pix == 0 && m_line == 1)) step(1'b1, md);
    endtask

    task automatic goto_last(int md);
        while (!(m_pix == f_tot(m_st) - 1 && m_line == f_n(m_st))) step(1'b1, md);
    endtask

    // Measure one whole frame from line 1 pixel 0 with enable held high.
    task automatic measure_frame(int md, int exp_act, int exp_wrap);
        int clocks, act1, act2, head, tail;
        bit in_head;
        clocks = 0; act1 = 0; act2 = 0; head = 0; tail = 0; in_head = 1'b1;
        do begin
            if (pix_count == '0) begin
                if (active && !field) act1++;
                if (active && field)  act2++;
                if (in_head && vblank) head++;
                else in_head = 1'b0;
                if (int'(line_count) == f_n(md) && vblank) tail++;
            end
            step(1'b1, md);
            clocks++;
        end while (!(pix_count == '0 && line_count == 10'd1));
        chk(clocks == f_tot(md) * f_n(md), "R2", "clocks per frame", clocks, f_tot(md) * f_n(md));
        chk(act1 == exp_act, "R6", "field-1 active lines", act1, exp_act);
        chk(act2 == exp_act, "R6", "field-2 active lines", act2, exp_act);
        chk(head + tail == exp_wrap, "R5", "blank lines across wrap", head + tail, exp_wrap);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == WDOG) begin
            n_cmp++; n_bad++;
            $display("FAIL R2 watchdog: actual %0d cycles expected fewer than %0d", cyc, WDOG);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        int md;
        void'($urandom(32'd4242));
        repeat (3) @(posedge clk);
        @(negedge clk);
        compare_all();
        chk(pix_count == '0 && line_count == 10'd1, "R1", "reset counters", int'(pix_count), 0);
        rst_n = 1'b1;

        // R1: codes 0 and 3 keep the block off
        for (int i = 0; i < 6; i++) step(1'b1, (i % 2) ? 3 : 0);
        chk(!vblank && !hblank && !active && !field, "R1", "off flags", vblank, 0);

        // R8: leaving off takes the format on the next clock
        step(1'b1, 1);
        chk(line_count == 10'd1 && pix_count == '0, "R8", "start after off", int'(pix_count), 0);
        chk(vblank == 1'b1, "R5", "line 1 blank", vblank, 1);
        measure_frame(1, 240, 22);

        // R8: mid-frame request for 625 lines, applied only at the wrap
        for (int i = 0; i < 3000; i++) step(1'b1, 2);
        chk(m_st == 1 && int'(line_count) <= 525, "R8", "format held mid-frame", int'(line_count), m_line);
        goto_start(2);
        measure_frame(2, 288, 24);

        // R8/R9 collision: last pixel of line N, request pending, enable low
        goto_last(2);
        step(1'b0, 1);
        chk(int'(pix_count) == A + H6 - 1 && line_count == 10'd625, "R9", "hold at wrap",
            int'(line_count), 625);
        step(1'b1, 1);
        chk(pix_count == '0 && line_count == 10'd1, "R8", "wrap into new format", int'(line_count), 1);
        for (int i = 0; i < 12 * 262; i++) step(1'b1, 1);
        chk(int'(line_count) == 263 && field == 1'b1, "R7", "field 2 begins", int'(line_count), 263);
        chk(vblank == 1'b1, "R4", "line 263 blank", vblank, 1);

        // Random enable gaps and format requests
        md = 1;
        for (int i = 0; i < 40000; i++) begin
            if ($urandom % 5000 == 0) md = $urandom % 4;
            step(($urandom % 6) != 0, md);
        end

        // Switch off at a frame boundary
        if (m_st == 0) step(1'b1, 2);
        goto_last(m_st);
        step(1'b1, 0);
        step(1'b1, 0);
        chk(!vblank && !field && pix_count == '0, "R1", "off after wrap", vblank, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule